// File: doc/BRIEF.md
# DTMF Tone-Pair Frequency Counter

This block measures the two limited square waves of a dual-tone receiver (one carrying the low-group tone and one carrying the high-group tone) against a fixed reference clock. Each input passes through a synchronizer. The block counts reference-clock cycles between successive rising edges and sorts each measured period into one of four frequency bins for that group. A bin is accepted only when the period lies inside a narrow tolerance window.

A group becomes valid only after several consecutive periods have fallen into the same bin. Voice and other short bursts rarely hold one frequency that long, so they are rejected. While both groups are valid the block raises a signal-condition flag and presents a 4-bit key code for the pair. The flag drops as soon as a period falls outside the window or moves to a different bin. It also drops when an input goes silent for longer than the slowest valid period plus a margin.

Top module: `dtmf_pair_counter`

## Requirements
- R1: After reset the signal-condition flag is 0 and the key code output is 0.
- R2: A period P (clock cycles between successive rising edges) matches a tone of nominal frequency f when |P - N| <= floor(N*15/1000), where N = floor(CLK_HZ/f). Any period that deviates from every nominal by 3.5% or more matches no bin.
- R3: The low group uses bins 697, 770, 852 and 941 Hz as row indices 0 to 3. The high group uses 1209, 1336, 1477 and 1633 Hz as column indices 0 to 3.
- R4: A group becomes valid once four consecutive measured periods match the same bin. The first rising edge after reset or after a timeout only starts a measurement and yields no period.
- R5: The flag is high exactly while both groups are valid. It falls within 4 clock cycles of a rising edge that ends a period matching no bin or a different bin.
- R6: If no rising edge arrives for LIMIT cycles, that group becomes invalid at once. LIMIT = N697 + floor(N697*15/1000) + floor(N697/16).
- R7: The key code for row r and column c follows the keypad rows "1 2 3 A", "4 5 6 B", "7 8 9 C" and "* 0 # D". Digits 1 to 9 encode as their value, 0 as 10, * as 11, # as 12, and A, B, C, D as 13, 14, 15, 0.
- R8: While the flag is high the code shows the current pair and does not change. While the flag is low the code holds the last valid pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tone_lo_i | input | 1 | Limited low-group tone, asynchronous |
| tone_hi_i | input | 1 | Limited high-group tone, asynchronous |
| pair_valid_o | output | 1 | Signal-condition flag |
| pair_code_o | output | 4 | Key code of the detected pair |

## Verification
One group can finish its fourth matching period in the same cycle that the other group rejects a period or times out. In that case the flag must stay low, and the code must keep its old value and not take a half-formed pair. The bench provokes this by running the two tones at unrelated random periods, so their edges land in every relative phase. It also injects a single off-window period into one group while the other stays locked. Each case is judged by comparing the flag and code at the ports with values the bench computes from the window and keypad rules.

// File: rtl/dtmf_pc_pkg.sv
package dtmf_pc_pkg;

  typedef struct packed {
    logic       hit;
    logic [1:0] idx;
  } bin_t;

  // group 0 = low tones, group 1 = high tones, idx ascending in frequency
  function automatic int unsigned tone_hz(input int grp, input int idx);
    case (grp * 4 + idx)
      0: return 697;
      1: return 770;
      2: return 852;
      3: return 941;
      4: return 1209;
      5: return 1336;
      6: return 1477;
      default: return 1633;
    endcase
  endfunction

  function automatic int unsigned nominal_period(input int unsigned clk_hz, input int grp, input int idx);
    return clk_hz / tone_hz(grp, idx);
  endfunction

  function automatic int unsigned window_half(input int unsigned nom, input int unsigned permille);
    return (nom * permille) / 1000;
  endfunction

  function automatic int unsigned period_limit(input int unsigned clk_hz, input int unsigned permille,
                                               input int unsigned margin_div);
    int unsigned slow;
    slow = nominal_period(clk_hz, 0, 0);
    return slow + window_half(slow, permille) + slow / margin_div;
  endfunction

  function automatic bin_t classify(input int unsigned per, input int unsigned clk_hz, input int grp,
                                    input int unsigned permille);
    bin_t r;
    int unsigned nom;
    int unsigned half;
    r = '0;
    for (int i = 0; i < 4; i++) begin
      nom  = nominal_period(clk_hz, grp, i);
      half = window_half(nom, permille);
      if ((per + half >= nom) && (per <= nom + half)) begin
        r.hit = 1'b1;
        r.idx = 2'(i);
      end
    end
    return r;
  endfunction

  function automatic logic [3:0] pair_code(input logic [1:0] row, input logic [1:0] col);
    if (col == 2'd3) begin
      return (row == 2'd3) ? 4'd0 : 4'(13 + int'(row));
    end else if (row == 2'd3) begin
      return (col == 2'd0) ? 4'd11 : ((col == 2'd1) ? 4'd10 : 4'd12);
    end else begin
      return 4'(int'(row) * 3 + int'(col) + 1);
    end
  endfunction

endpackage

// File: rtl/edge_sync.sv
module edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise
);
  logic [STAGES:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-1:0], din};
  end

  assign rise = chain[STAGES-1] & ~chain[STAGES];
endmodule

// File: rtl/period_meter.sv
module period_meter #(
  parameter int unsigned LIMIT = 300,
  parameter int CW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rise,
  output logic          meas_stb,
  output logic [CW-1:0] meas_per,
  output logic          timeout
);
  localparam logic [CW-1:0] LIM = CW'(LIMIT);

  logic [CW-1:0] cnt;
  logic          armed;

  assign timeout  = armed && !rise && (cnt == LIM);
  assign meas_stb = armed && rise;
  assign meas_per = cnt + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= LIM;
      armed <= 1'b0;
    end else if (rise) begin
      cnt   <= '0;
      armed <= 1'b1;
    end else begin
      if (cnt != LIM) cnt <= cnt + 1'b1;
      if (timeout)    armed <= 1'b0;
    end
  end

  AST_TIMEOUT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    timeout |=> !timeout); // R6
  AST_TIMEOUT_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
    timeout |=> !meas_stb); // R4
endmodule

// File: rtl/group_tracker.sv
module group_tracker
  import dtmf_pc_pkg::*;
#(
  parameter int unsigned CLK_HZ   = 3_579_545,
  parameter int          GRP      = 0,
  parameter int unsigned PERMILLE = 15,
  parameter int unsigned RUNS     = 4,
  parameter int          CW       = 13
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          meas_stb,
  input  logic [CW-1:0] meas_per,
  input  logic          timeout,
  output logic          valid,
  output logic [1:0]    idx
);
  localparam int RW = $clog2(RUNS + 1);
  localparam logic [RW-1:0] RUN_FULL = RW'(RUNS);

  bin_t          bin;
  logic [RW-1:0] run;
  logic [1:0]    last;

  assign bin   = classify(32'(meas_per), CLK_HZ, GRP, PERMILLE);
  assign valid = (run == RUN_FULL);
  assign idx   = last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run  <= '0;
      last <= '0;
    end else if (timeout) begin
      run <= '0;
    end else if (meas_stb) begin
      if (!bin.hit) begin
        run <= '0;
      end else if ((bin.idx == last) && (run != '0)) begin
        if (run != RUN_FULL) run <= run + 1'b1;
      end else begin
        run  <= RW'(1);
        last <= bin.idx;
      end
    end
  end

  AST_RUN_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    run <= RUN_FULL); // R4
  AST_RISE_AFTER_MEAS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(valid) |-> $past(meas_stb && bin.hit)); // R4
  AST_MISS_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (meas_stb && !bin.hit) |=> !valid); // R5
  AST_TIMEOUT_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    timeout |=> !valid); // R6
endmodule

// File: rtl/dtmf_pair_counter.sv
module dtmf_pair_counter
  import dtmf_pc_pkg::*;
#(
  parameter int unsigned CLK_HZ       = 3_579_545,
  parameter int unsigned TOL_PERMILLE = 15,
  parameter int unsigned RUNS         = 4,
  parameter int unsigned MARGIN_DIV   = 16,
  parameter int          SYNC_STAGES  = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tone_lo_i,
  input  logic       tone_hi_i,
  output logic       pair_valid_o,
  output logic [3:0] pair_code_o
);
  localparam int unsigned LIMIT = period_limit(CLK_HZ, TOL_PERMILLE, MARGIN_DIV);
  localparam int CW = $clog2(LIMIT + 2);

  logic [1:0] tone_raw;
  logic [1:0] grp_ok;
  logic [1:0] grp_idx [2];
  logic [3:0] held_code;
  logic [3:0] live_code;

  assign tone_raw = {tone_hi_i, tone_lo_i};

  for (genvar g = 0; g < 2; g++) begin : g_grp
    logic          rise_w;
    logic          stb_w;
    logic          to_w;
    logic [CW-1:0] per_w;

    edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .din(tone_raw[g]), .rise(rise_w)
    );

    period_meter #(.LIMIT(LIMIT), .CW(CW)) u_meter (
      .clk(clk), .rst_n(rst_n), .rise(rise_w),
      .meas_stb(stb_w), .meas_per(per_w), .timeout(to_w)
    );

    group_tracker #(
      .CLK_HZ(CLK_HZ), .GRP(g), .PERMILLE(TOL_PERMILLE), .RUNS(RUNS), .CW(CW)
    ) u_track (
      .clk(clk), .rst_n(rst_n), .meas_stb(stb_w), .meas_per(per_w),
      .timeout(to_w), .valid(grp_ok[g]), .idx(grp_idx[g])
    );
  end

  assign live_code    = pair_code(grp_idx[0], grp_idx[1]);
  assign pair_valid_o = grp_ok[0] & grp_ok[1];
  assign pair_code_o  = pair_valid_o ? live_code : held_code;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            held_code <= 4'd0;
    else if (pair_valid_o) held_code <= live_code;
  end

  AST_CODE_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    (pair_valid_o && $past(pair_valid_o)) |-> $stable(pair_code_o)); // R8
  AST_CODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!pair_valid_o && !$past(pair_valid_o)) |-> $stable(pair_code_o)); // R8
endmodule

// File: tb/dtmf_pair_counter_test.sv
`timescale 1ns/1ps
module dtmf_pair_counter_test;
  localparam int CLK_HZ = 200_000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tone_lo = 1'b0;
  logic       tone_hi = 1'b0;
  logic       pv;
  logic [3:0] pc;

  int cyc = 0;
  int checks = 0;
  int errors = 0;
  int last_rise [2];
  int exp_code = 0;
  bit done = 0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  dtmf_pair_counter #(.CLK_HZ(CLK_HZ)) uut (
    .clk(clk), .rst_n(rst_n), .tone_lo_i(tone_lo), .tone_hi_i(tone_hi),
    .pair_valid_o(pv), .pair_code_o(pc)
  );

  function automatic int freq(input int g, input int i);
    int lo [4] = '{697, 770, 852, 941};
    int hi [4] = '{1209, 1336, 1477, 1633};
    return g ? hi[i] : lo[i];
  endfunction
  function automatic int nom(input int g, input int i);
    return CLK_HZ / freq(g, i);
  endfunction
  function automatic int tol(input int n);
    return n * 15 / 1000;
  endfunction
  function automatic int limit_cyc();
    return nom(0, 0) + tol(nom(0, 0)) + nom(0, 0) / 16;
  endfunction
  function automatic int key(input int r, input int c);
    string pad = "123A456B789C*0#D";
    byte ch;
    ch = pad[r * 4 + c];
    case (ch)
      "*": return 11;
      "#": return 12;
      "0": return 10;
      "A": return 13;
      "B": return 14;
      "C": return 15;
      "D": return 0;
      default: return int'(ch) - 48;
    endcase
  endfunction
  function automatic int bad_off(input int n);
    int o;
    o = n * (40 + int'($urandom % 20)) / 1000 + 1;
    return ($urandom % 2) ? o : -o;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic run_tone(input int g, input int p, input int n);
    for (int k = 0; k < n; k++) begin
      if (g == 0) tone_lo = 1'b1; else tone_hi = 1'b1;
      last_rise[g] = cyc;
      repeat (p / 2) @(negedge clk);
      if (g == 0) tone_lo = 1'b0; else tone_hi = 1'b0;
      repeat (p - p / 2) @(negedge clk);
    end
  endtask

  task automatic idle();
    repeat (2 * limit_cyc() + 20) @(negedge clk);
  endtask

  // both tones from idle, judged after 2000 cycles while both still run
  task automatic pair_test(input int r, input int c, input int pl, input int ph,
                           input bit exp_ok, input string req);
    fork
      run_tone(0, pl, 2000 / pl + 2);
      run_tone(1, ph, 2000 / ph + 2);
      begin
        repeat (2000) @(negedge clk);
        chk(pv == exp_ok, req, pv, exp_ok);
        if (exp_ok) exp_code = key(r, c);
        chk(pc == 4'(exp_code), "R7/R8 code", pc, exp_code);
      end
    join
    idle();
  endtask

  task automatic short_burst(input int k, input bit exp_ok);
    int pl, ph;
    pl = nom(0, 1);
    ph = nom(1, 2);
    fork
      run_tone(0, pl, (1500 + k * ph + 40) / pl + 2);
      begin
        repeat (1500) @(negedge clk);
        run_tone(1, ph, k);
        repeat (5) @(negedge clk);
        chk(pv == exp_ok, "R4 run length", pv, exp_ok);
        if (exp_ok) exp_code = key(1, 2);
        chk(pc == 4'(exp_code), "R8 code after burst", pc, exp_code);
      end
    join
    idle();
  endtask

  initial begin
    void'($urandom(32'd4711));
    repeat (5) @(negedge clk);
    chk(pv == 1'b0, "R1 flag", pv, 0);
    chk(pc == 4'd0, "R1 code", pc, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(pv == 1'b0, "R1 flag after release", pv, 0);

    // R3 R7: every pair at nominal period
    for (int r = 0; r < 4; r++)
      for (int c = 0; c < 4; c++)
        pair_test(r, c, nom(0, r), nom(1, c), 1'b1, "R3 nominal pair");

    // R2: window edges accepted, 3.5% rejected
    pair_test(0, 3, nom(0, 0) + tol(nom(0, 0)), nom(1, 3) - tol(nom(1, 3)), 1'b1, "R2 window edge");
    pair_test(3, 0, nom(0, 3) - tol(nom(0, 3)), nom(1, 0) + tol(nom(1, 0)), 1'b1, "R2 window edge");
    pair_test(2, 1, nom(0, 2) + (nom(0, 2) * 35 + 999) / 1000, nom(1, 1), 1'b0, "R2 low 3.5% off");
    pair_test(1, 2, nom(0, 1), nom(1, 2) - (nom(1, 2) * 35 + 999) / 1000, 1'b0, "R2 high 3.5% off");

    // R4: four edges give three periods, five give four
    short_burst(4, 1'b0);
    short_burst(5, 1'b1);

    // random pairs, offsets inside or clearly outside the window
    for (int t = 0; t < 16; t++) begin
      int r, c, mode, pl, ph;
      r = int'($urandom % 4);
      c = int'($urandom % 4);
      mode = int'($urandom % 4);
      pl = nom(0, r) + int'($urandom % (2 * tol(nom(0, r)) + 1)) - tol(nom(0, r));
      ph = nom(1, c) + int'($urandom % (2 * tol(nom(1, c)) + 1)) - tol(nom(1, c));
      if (mode == 0) pl = nom(0, r) + bad_off(nom(0, r));
      if (mode == 1) ph = nom(1, c) + bad_off(nom(1, c));
      pair_test(r, c, pl, ph, mode > 1, "R2/R5 random pair");
    end

    // R5: one off-window high period while low stays locked
    begin
      int pl, ph;
      pl = nom(0, 2);
      ph = nom(1, 0);
      fork
        run_tone(0, pl, (1500 + 14 * ph) / pl + 2);
        begin
          repeat (1500) @(negedge clk);
          run_tone(1, ph, 6);
          chk(pv == 1'b1, "R5 locked before glitch", pv, 1);
          run_tone(1, ph + ph * 5 / 100, 1);
          fork
            run_tone(1, ph, 5);
            begin
              repeat (ph / 2) @(negedge clk);
              chk(pv == 1'b0, "R5 drop on off period", pv, 0);
              chk(pc == 4'(key(2, 0)), "R8 code held", pc, key(2, 0));
            end
          join
          repeat (5) @(negedge clk);
          chk(pv == 1'b1, "R5 relock", pv, 1);
          exp_code = key(2, 0);
        end
      join
      idle();
    end

    // R6: high tone stops, flag drops at the silence limit
    begin
      int pl, ph, t0;
      pl = nom(0, 3);
      ph = nom(1, 3);
      fork
        run_tone(0, pl, (1500 + 6 * ph + limit_cyc() + 60) / pl + 2);
        begin
          repeat (1500) @(negedge clk);
          run_tone(1, ph, 6);
          t0 = last_rise[1];
          while (cyc < t0 + limit_cyc() - 8) @(negedge clk);
          chk(pv == 1'b1, "R6 before limit", pv, 1);
          while (cyc < t0 + limit_cyc() + 12) @(negedge clk);
          chk(pv == 1'b0, "R6 after limit", pv, 0);
          chk(pc == 4'(key(3, 3)), "R8 code held after timeout", pc, key(3, 3));
        end
      join
      idle();
    end

    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (190000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 190000);
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule